// File: doc/BRIEF.md
# Platform interrupt claim arbiter

This block gathers level-sensitive interrupt requests from a set of numbered sources, with number 0 reserved to mean "nothing". It arbitrates them for a small number of target contexts. Each source has a gateway and one pending bit. The gateway latches a request into the pending bit and then keeps further requests from that source out until the service of the current one is reported complete. Each source carries a priority. Each context carries its own enable mask and priority threshold.

Every context gets an interrupt-notify line. The line rises only for pending, enabled sources whose priority is above that context's threshold. A context reads the best candidate on its claim-ID output. It claims by pulsing its claim strobe: the source shown is taken in that cycle, its pending bit clears on the same edge and its gateway closes. When software has serviced the source, it pulses the complete strobe with that source number and the gateway opens again. Configuration goes through one synchronous write port that carries a register select, an index and a data word.

Top module: `irq_claim_arb`

## Requirements
- R1: A source whose priority is 0 never contributes to any context's notify line, even while its pending bit is set.
- R2: A source whose priority is 0 is never shown on any claim-ID output, and it is never cleared by a claim.
- R3: `notify_o[k]` is 1 exactly when some source with a set pending bit is enabled for context k and has a priority strictly greater than context k's threshold.
- R4: The claim-ID output ignores the threshold. It shows the best pending, enabled, nonzero-priority source even when that source's priority is at or below the threshold.
- R5: Pending bits are held per source and shown on `pending_o` whatever the enable masks are. Bit 0 is always 0. A gateway that is open and sees its request high sets the pending bit on the next clock edge.
- R6: The claim-ID for context k is the eligible source with the highest priority, with the lowest source number winning a tie. The output is combinational in the same cycle. A claim strobe clears that source's pending bit on the next edge.
- R7: When no eligible source exists for a context, its claim-ID is 0, and a claim from it changes no pending or gateway state.
- R8: After a claim, the source's pending bit stays 0 while its request stays high, until a valid completion for that source. If the request is still high, the pending bit sets again on the edge after the completion edge.
- R9: A completion is ignored when the number it gives is not enabled in the completing context's mask. The gateway stays closed.
- R10: When several contexts claim in the same cycle, lower-numbered contexts take their sources first. A higher-numbered context is shown the next-best source not already taken, or 0.
- R11: The write port updates a register on the clock edge while `cfg_we_i` is 1. The select codes are: 0 = priority, where the index is the source number and the low `PRIO_W` bits of the data are used; 1 = enable mask, where the index is the context and all `NUM_SRC` data bits are the mask, bit s enabling source s; 2 = threshold, where the index is the context and the low `PRIO_W` bits are used. Select code 3 and out-of-range indices write nothing. All of these registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_SRC | Level request per source; bit 0 unused |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 priority, 1 enable mask, 2 threshold |
| cfg_idx_i | input | IDX_W | Source number or context number |
| cfg_wdata_i | input | NUM_SRC | Write data |
| claim_i | input | NUM_CTX | Claim strobe per context |
| claim_id_o | output | NUM_CTX*ID_W | Source each context would claim now, packed with context k in bits [k*ID_W +: ID_W] |
| complete_i | input | NUM_CTX | Completion strobe per context |
| complete_id_i | input | NUM_CTX*ID_W | Source number completed, one field per context |
| notify_o | output | NUM_CTX | Interrupt-notify line per context |
| pending_o | output | NUM_SRC | Pending bit per source |

## Verification
The bench holds a priority-0 source pending. A design that lets priority 0 through would raise notify or hand out that source. It then lifts a context's threshold above the waiting priority: a claim path that wrongly applies the threshold returns 0 and leaves the source stranded. Tied priorities and simultaneous claims from both contexts are driven to expose arbitration that favours the higher source number, or two contexts both given one source. Held-high requests across a claim, a completion from a context without the enable, and then a proper completion show whether a gateway re-pends too early, accepts a foreign completion or never reopens.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    CFG_PRIO = 2'd0,
    CFG_EN   = 2'd1,
    CFG_THR  = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int IDX_W   = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  cfg_sel_e                          sel_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [NUM_SRC-1:0]                wdata_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_o,
  output logic [NUM_CTX-1:0][NUM_SRC-1:0]   en_o,
  output logic [NUM_CTX-1:0][PRIO_W-1:0]    thr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_o <= '0;
      en_o   <= '0;
      thr_o  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        CFG_PRIO: if (int'(idx_i) < NUM_SRC) prio_o[idx_i] <= wdata_i[PRIO_W-1:0];
        CFG_EN:   if (int'(idx_i) < NUM_CTX) en_o[idx_i]   <= wdata_i;
        CFG_THR:  if (int'(idx_i) < NUM_CTX) thr_o[idx_i]  <= wdata_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o,
  output logic infl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      infl_o <= 1'b0;
    end else begin
      pend_o <= claim_i ? 1'b0 : (pend_o | (req_i & ~infl_o));
      if (claim_i)         infl_o <= 1'b1;
      else if (complete_i) infl_o <= 1'b0;
    end
  end

  // closed gateway must not hold a pending bit
  assert_inflight_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    infl_o |-> !pend_o);
endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4
) (
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [NUM_SRC-1:0]             en_i,
  input  logic [PRIO_W-1:0]              thr_i,
  input  logic [NUM_SRC-1:0]             excl_i,
  output logic [ID_W-1:0]                id_o,
  output logic                           notify_o
);
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] above;
  logic [PRIO_W-1:0]  best_p;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      cand[s]  = (s != 0) && pend_i[s] && en_i[s] && !excl_i[s] && (prio_i[s] != '0);
      above[s] = (s != 0) && pend_i[s] && en_i[s] && (prio_i[s] > thr_i);
    end
  end

  // ascending scan with strict compare keeps the lowest ID on ties
  always_comb begin
    id_o   = '0;
    best_p = '0;
    for (int s = 1; s < NUM_SRC; s++) begin
      if (cand[s] && prio_i[s] > best_p) begin
        best_p = prio_i[s];
        id_o   = ID_W'(s);
      end
    end
  end

  assign notify_o = |above;
endmodule

// File: rtl/irq_claim_arb.sv
module irq_claim_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  localparam int ID_W  = $clog2(NUM_SRC),
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int IDX_W = (ID_W > CTX_W) ? ID_W : CTX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_SRC-1:0]      irq_req_i,
  input  logic                    cfg_we_i,
  input  logic [1:0]              cfg_sel_i,
  input  logic [IDX_W-1:0]        cfg_idx_i,
  input  logic [NUM_SRC-1:0]      cfg_wdata_i,
  input  logic [NUM_CTX-1:0]      claim_i,
  output logic [NUM_CTX*ID_W-1:0] claim_id_o,
  input  logic [NUM_CTX-1:0]      complete_i,
  input  logic [NUM_CTX*ID_W-1:0] complete_id_i,
  output logic [NUM_CTX-1:0]      notify_o,
  output logic [NUM_SRC-1:0]      pending_o
);
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_w;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en_w;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_w;
  logic [NUM_SRC-1:0]              pend_w, infl_w, clm_w, comp_w;
  logic [NUM_SRC-1:0]              excl [NUM_CTX+1];
  logic [ID_W-1:0]                 cid  [NUM_CTX];

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_e'(cfg_sel_i)),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .prio_o  (prio_w),
    .en_o    (en_w),
    .thr_o   (thr_w)
  );

  assign excl[0] = '0;

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_ctx
    irq_ctx_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .pend_i   (pend_w),
      .prio_i   (prio_w),
      .en_i     (en_w[k]),
      .thr_i    (thr_w[k]),
      .excl_i   (excl[k]),
      .id_o     (cid[k]),
      .notify_o (notify_o[k])
    );
    // lower contexts take their pick first
    assign excl[k+1] = excl[k] |
      ((claim_i[k] && cid[k] != '0) ? (NUM_SRC'(1) << cid[k]) : '0);
    assign claim_id_o[k*ID_W +: ID_W] = cid[k];

    assert_prio0_no_claim_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cid[k] != '0) |-> (prio_w[cid[k]] != '0));
    assert_claim_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_i[k] && cid[k] != '0) |=> !pending_o[$past(cid[k])]);
    if (k > 0) begin : g_pair
      assert_distinct_claims_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_i[0] && claim_i[k] && cid[k] != '0) |-> (cid[k] != cid[0]));
    end
  end

  assign clm_w = excl[NUM_CTX] & ~NUM_SRC'(1);

  always_comb begin
    comp_w = '0;
    for (int k = 0; k < NUM_CTX; k++)
      for (int s = 1; s < NUM_SRC; s++)
        if (complete_i[k] && complete_id_i[k*ID_W +: ID_W] == ID_W'(s) && en_w[k][s])
          comp_w[s] = 1'b1;
  end

  assign pend_w[0] = 1'b0;
  assign infl_w[0] = 1'b0;
  for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
    irq_gateway u_gw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (irq_req_i[s]),
      .claim_i    (clm_w[s]),
      .complete_i (comp_w[s]),
      .pend_o     (pend_w[s]),
      .infl_o     (infl_w[s])
    );
  end

  assign pending_o = pend_w;

  // a raised notify always has something to claim
  assert_notify_has_claim_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o[0] |-> (cid[0] != '0));
endmodule

// File: tb/irq_claim_arb_tb.sv
module irq_claim_arb_tb;
  localparam int NS = 16;
  localparam int NC = 2;
  localparam int PW = 3;
  localparam int IW = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NS-1:0]    req = '0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_sel = '0;
  logic [IW-1:0]    cfg_idx = '0;
  logic [NS-1:0]    cfg_wdata = '0;
  logic [NC-1:0]    claim = '0;
  logic [NC*IW-1:0] claim_id;
  logic [NC-1:0]    complete = '0;
  logic [NC*IW-1:0] complete_id = '0;
  logic [NC-1:0]    notify;
  logic [NS-1:0]    pending;

  always #10 clk = ~clk;

  irq_claim_arb #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .claim_i(claim), .claim_id_o(claim_id),
    .complete_i(complete), .complete_id_i(complete_id),
    .notify_o(notify), .pending_o(pending)
  );

  // reference model state
  int prio_m [NS];
  bit en_m   [NC][NS];
  int thr_m  [NC];
  bit pend_m [NS];
  bit infl_m [NS];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    int ids [NC];
    bit taken [NS];
    int pexp;
    bit np [NS];
    bit ni [NS];
    #1;
    foreach (taken[s]) taken[s] = 0;
    for (int k = 0; k < NC; k++) begin
      int best = 0;
      int bp = 0;
      bit nt = 0;
      for (int s = 1; s < NS; s++) begin
        if (pend_m[s] && en_m[k][s] && !taken[s] && prio_m[s] > bp) begin
          bp = prio_m[s];
          best = s;
        end
        if (pend_m[s] && en_m[k][s] && prio_m[s] > 0 && prio_m[s] > thr_m[k]) nt = 1;
      end
      ids[k] = best;
      if (claim[k] && best != 0) taken[best] = 1;
      chk(tag, $sformatf("claim_id ctx%0d", k), int'(claim_id[k*IW +: IW]), best);
      chk(tag, $sformatf("notify ctx%0d", k), int'(notify[k]), int'(nt));
    end
    pexp = 0;
    for (int s = 0; s < NS; s++) if (pend_m[s]) pexp |= (1 << s);
    chk(tag, "pending", int'(pending), pexp);
    @(posedge clk);
    if (rst_n) begin
      for (int s = 1; s < NS; s++) begin
        bit cmp = 0;
        for (int k = 0; k < NC; k++)
          if (complete[k] && int'(complete_id[k*IW +: IW]) == s && en_m[k][s]) cmp = 1;
        np[s] = taken[s] ? 0 : (pend_m[s] || (req[s] && !infl_m[s]));
        ni[s] = taken[s] ? 1 : (cmp ? 0 : infl_m[s]);
      end
      for (int s = 1; s < NS; s++) begin
        pend_m[s] = np[s];
        infl_m[s] = ni[s];
      end
      if (cfg_we) begin
        if (cfg_sel == 2'd0 && int'(cfg_idx) < NS) prio_m[cfg_idx] = int'(cfg_wdata[PW-1:0]);
        if (cfg_sel == 2'd1 && int'(cfg_idx) < NC)
          for (int s = 0; s < NS; s++) en_m[cfg_idx][s] = cfg_wdata[s];
        if (cfg_sel == 2'd2 && int'(cfg_idx) < NC) thr_m[cfg_idx] = int'(cfg_wdata[PW-1:0]);
      end
    end
    @(negedge clk);
    cfg_we = 0;
    claim = '0;
    complete = '0;
  endtask

  task automatic cfg(string tag, int sel, int idx, int data);
    cfg_we = 1;
    cfg_sel = 2'(sel);
    cfg_idx = IW'(idx);
    cfg_wdata = NS'(data);
    step(tag);
  endtask

  task automatic do_claim(string tag, logic [NC-1:0] c);
    claim = c;
    step(tag);
  endtask

  task automatic do_complete(string tag, int k, int id);
    complete[k] = 1'b1;
    complete_id[k*IW +: IW] = IW'(id);
    step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (prio_m[s]) begin prio_m[s] = 0; pend_m[s] = 0; infl_m[s] = 0; end
    foreach (thr_m[k]) thr_m[k] = 0;
    foreach (en_m[k, s]) en_m[k][s] = 0;
    repeat (3) @(negedge clk);
    req = '1;
    step("R11");            // reset holds everything at 0
    req = '0;
    rst_n = 1'b1;
    step("R11");

    cfg("R11", 0, 3, 2);
    cfg("R11", 0, 5, 2);
    cfg("R11", 0, 7, 0);
    cfg("R11", 0, 9, 5);
    cfg("R11", 3, 9, 7);    // unused select writes nothing
    cfg("R11", 1, 0, 'hFFFE);
    cfg("R11", 1, 1, 'h0208);
    cfg("R11", 2, 1, 4);

    req[7] = 1'b1;          // priority-0 source
    step("R5");
    step("R1");
    do_claim("R2", 2'b01);
    do_claim("R7", 2'b11);  // no eligible source: nothing changes
    step("R7");

    req[3] = 1'b1;
    req[5] = 1'b1;
    step("R5");
    step("R3");
    do_claim("R6", 2'b01);  // tie 3 vs 5: lowest ID
    step("R8");
    step("R8");

    cfg("R3", 2, 0, 3);     // threshold 3 hides prio-2 source 5 from notify
    step("R3");
    do_claim("R4", 2'b01);  // claim still returns 5
    step("R8");

    do_complete("R9", 1, 5);  // ctx1 does not enable 5
    step("R9");
    step("R9");
    do_complete("R8", 0, 5);
    step("R8");
    step("R8");

    do_complete("R8", 0, 3);
    step("R8");
    req[9] = 1'b1;
    step("R5");
    step("R3");
    do_claim("R10", 2'b11);  // ctx0 takes 9, ctx1 takes 3
    step("R10");
    do_claim("R10", 2'b11);  // ctx0 takes 5, ctx1 has nothing
    step("R10");

    cfg("R5", 1, 0, 'hF7FE);  // ctx0 no longer enables 11
    req[11] = 1'b1;
    step("R5");
    step("R5");
    do_claim("R5", 2'b11);
    step("R5");

    req = '0;
    do_complete("R8", 0, 9);
    do_complete("R8", 1, 3);
    step("R8");
    step("R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule